// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits between five request sources and a small CPU. The sources are two external lines, two timer overflows and a serial port. The serial port raises a request when it has received a byte or finished sending one. Each request is held in a flag register. Hardware sets a flag with a one-cycle pulse, and software can overwrite the flags through a small register bus. A request is considered only when both its own enable bit and the global enable bit are set.

An enabled request is sorted into the low or high level by its priority bit. Within a level, a fixed polling order picks the winner. Two in-service bits record which levels the CPU is currently handling. A win is granted only if the nesting rules allow it: a high level interrupts only an idle CPU or low-level service, and a low level interrupts only an idle CPU. On a grant, the controller sends the CPU a one-cycle acknowledge together with a fixed vector address. It also sets the in-service bit for the winning level. The timer flags are cleared at that moment; every other flag is left for software to clear. A return pulse from the CPU clears the highest in-service bit that is set.

Top module: `vic_top`

## Requirements
- R1: The vectors are 0x0003 for external 0, 0x000B for timer 0, 0x0013 for external 1, 0x001B for timer 1 and 0x0023 for serial.
- R2: Register address 0 holds the enables. Bit 7 is the global enable and bits 4..0 enable serial, timer 1, external 1, timer 0 and external 0, from bit 4 down to bit 0. Bits 6 and 5 always read 0.
- R3: While the global enable bit is 0, no acknowledge is issued, whatever the individual enables hold.
- R4: After reset, the enable, priority and flag registers read 0, both in-service bits are clear, and `ack_o` is 0.
- R5: Register address 1 holds one priority bit per source, in the same bit positions as the enables (1 = high). When requests of both levels are pending together, a high-level request is acknowledged first.
- R6: While high-level service is active, nothing is acknowledged. While only low-level service is active, only a high-level request is acknowledged.
- R7: When several requests of the same level are pending together, they are served in the order external 0, timer 0, external 1, timer 1, serial.
- R8: Taking the timer 0 or timer 1 vector clears that timer's flag.
- R9: The flag register (address 2) has separate receive (bit 4) and transmit (bit 5) serial flags. The serial request is their OR. Neither serial flag, and neither external flag, is cleared when its vector is taken.
- R10: The flag register holds bit 0 external 0, bit 1 timer 0, bit 2 external 1, bit 3 timer 1, bit 4 receive and bit 5 transmit. A software write that sets a flag raises a request exactly as a hardware set does. A software write that clears a pending flag cancels the request.
- R11: `ack_o` pulses high for one cycle, with `vector_o` valid, on the clock edge after the edge at which an allowed request becomes visible in the flag register.
- R12: A `reti_i` pulse clears the high in-service bit if it is set, otherwise the low one. Lower-level requests that are still pending are then served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 enable, 1 priority, 2 flags |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for the current address |
| evt_set_i | input | 6 | Hardware flag-set pulses, in the same bit order as the flag register |
| reti_i | input | 1 | Return-from-interrupt pulse from the CPU |
| ack_o | output | 1 | Interrupt acknowledge pulse |
| vector_o | output | 16 | Service routine address, valid while ack_o is high |

## Verification
The bench drives every level and order combination that a wrong priority tree or a wrong nesting test would mishandle:
- Five simultaneous low requests must come out in polling order; a reversed scan would issue 0x0023 first.
- A high request must beat an earlier-indexed low one.
- A low request raised during low service must wait, while a high one must preempt it. A controller that lets low preempt low would acknowledge too early.
- After a nested return, the outer low service must still block the pending low request. A return that cleared both bits would let it through.
- Flag handling is checked by reading the flag register back. Timer flags must be gone after vectoring, while the external and serial flags must stay.
- A flag cancelled by software must never be acknowledged, even once it is enabled.

// File: rtl/vic_pkg.sv
package vic_pkg;
  localparam int NSRC    = 5;
  localparam int FLAG_W  = 6;
  localparam int IDX_W   = $clog2(NSRC);
  localparam int GEN_BIT = 7;
  localparam int SRC_TMR0 = 1;
  localparam int SRC_TMR1 = 3;
  localparam int SRC_SER  = 4;
  localparam int FLG_RX   = 4;
  localparam int FLG_TX   = 5;
  // sources whose flag is cleared when their vector is taken
  localparam logic [NSRC-1:0] CLR_ON_VEC = 5'b01010;

  typedef enum logic [1:0] {
    ADDR_EN   = 2'd0,
    ADDR_PRI  = 2'd1,
    ADDR_FLAG = 2'd2
  } reg_addr_e;
endpackage

// File: rtl/vic_regs.sv
module vic_regs
  import vic_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [FLAG_W-1:0] hw_set_i,
  input  logic [NSRC-1:0]   take_i,
  output logic [NSRC-1:0]   req_o,
  output logic [NSRC-1:0]   pri_o,
  output logic              gen_o
);
  logic              gen_q;
  logic [NSRC-1:0]   en_q, pri_q;
  logic [FLAG_W-1:0] flag_q, flag_d;
  logic              flag_wr;

  assign flag_wr = we_i && (addr_i == ADDR_FLAG);

  always_comb begin
    flag_d = flag_q;
    if (flag_wr) flag_d = wdata_i[FLAG_W-1:0];
    for (int i = 0; i < NSRC; i++)
      if (CLR_ON_VEC[i] && take_i[i]) flag_d[i] = 1'b0;
    flag_d = flag_d | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gen_q  <= 1'b0;
      en_q   <= '0;
      pri_q  <= '0;
      flag_q <= '0;
    end else begin
      if (we_i && addr_i == ADDR_EN) begin
        gen_q <= wdata_i[GEN_BIT];
        en_q  <= wdata_i[NSRC-1:0];
      end
      if (we_i && addr_i == ADDR_PRI) pri_q <= wdata_i[NSRC-1:0];
      flag_q <= flag_d;
    end
  end

  logic [NSRC-1:0] raw;
  generate
    for (genvar g = 0; g < NSRC; g++) begin : g_raw
      if (g == SRC_SER) begin : g_ser
        assign raw[g] = flag_q[FLG_RX] | flag_q[FLG_TX];
      end else begin : g_one
        assign raw[g] = flag_q[g];
      end
    end
  endgenerate

  assign req_o = gen_q ? (raw & en_q) : '0;
  assign pri_o = pri_q;
  assign gen_o = gen_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_EN:   begin rdata_o[GEN_BIT] = gen_q; rdata_o[NSRC-1:0] = en_q; end
      ADDR_PRI:  rdata_o[NSRC-1:0] = pri_q;
      ADDR_FLAG: rdata_o[FLAG_W-1:0] = flag_q;
      default:   rdata_o = '0;
    endcase
  end

  AST_TMR0_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i[SRC_TMR0] && !hw_set_i[SRC_TMR0] && !flag_wr |=> !flag_q[SRC_TMR0]); // R8
  AST_TMR1_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i[SRC_TMR1] && !hw_set_i[SRC_TMR1] && !flag_wr |=> !flag_q[SRC_TMR1]); // R8
  AST_SER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i[SRC_SER] && !flag_wr |=>
      ((flag_q[FLG_TX:FLG_RX] & $past(flag_q[FLG_TX:FLG_RX])) == $past(flag_q[FLG_TX:FLG_RX]))); // R9
endmodule

// File: rtl/vic_arb.sv
module vic_arb
  import vic_pkg::*;
(
  input  logic [NSRC-1:0]  req_i,
  input  logic [NSRC-1:0]  pri_i,
  output logic             win_valid_o,
  output logic             win_hi_o,
  output logic [IDX_W-1:0] win_idx_o
);
  logic [NSRC-1:0]  hi_req, lo_req, sel;
  logic [IDX_W-1:0] idx;

  assign hi_req = req_i & pri_i;
  assign lo_req = req_i & ~pri_i;
  assign sel    = (|hi_req) ? hi_req : lo_req;

  // lowest index wins: scan from the top so earlier sources overwrite
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (sel[i]) idx = IDX_W'(i);
  end

  assign win_valid_o = |req_i;
  assign win_hi_o    = |hi_req;
  assign win_idx_o   = idx;
endmodule

// File: rtl/vic_svc.sv
module vic_svc
  import vic_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             win_valid_i,
  input  logic             win_hi_i,
  input  logic [IDX_W-1:0] win_idx_i,
  input  logic             reti_i,
  output logic [NSRC-1:0]  take_o,
  output logic             ack_o,
  output logic [VEC_W-1:0] vector_o
);
  logic isr_lo_q, isr_hi_q;
  logic grant;

  assign grant = win_valid_i && !isr_hi_q && (win_hi_i || !isr_lo_q);

  always_comb begin
    take_o = '0;
    if (grant) take_o[win_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      isr_lo_q <= 1'b0;
      isr_hi_q <= 1'b0;
      ack_o    <= 1'b0;
      vector_o <= '0;
    end else begin
      ack_o <= grant;
      if (grant) vector_o <= VEC_W'(VEC_BASE + VEC_STEP * int'(win_idx_i));
      if (grant && win_hi_i)       isr_hi_q <= 1'b1;
      else if (reti_i && isr_hi_q) isr_hi_q <= 1'b0;
      if (grant && !win_hi_i)                    isr_lo_q <= 1'b1;
      else if (reti_i && !isr_hi_q && isr_lo_q)  isr_lo_q <= 1'b0;
    end
  end

  AST_HI_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_hi_q |=> !ack_o); // R6
  AST_LO_NO_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    isr_lo_q && !win_hi_i |=> !ack_o); // R6
  AST_RETI_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && isr_hi_q |=> !isr_hi_q); // R12
  AST_RETI_KEEP_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reti_i && isr_hi_q && isr_lo_q |=> isr_lo_q); // R12
endmodule

// File: rtl/vic_top.sv
module vic_top
  import vic_pkg::*;
#(
  parameter int VEC_W    = 16,
  parameter int VEC_BASE = 3,
  parameter int VEC_STEP = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic [FLAG_W-1:0] evt_set_i,
  input  logic              reti_i,
  output logic              ack_o,
  output logic [VEC_W-1:0]  vector_o
);
  logic [NSRC-1:0]  req, pri, take;
  logic             gen, win_valid, win_hi;
  logic [IDX_W-1:0] win_idx;

  vic_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .hw_set_i(evt_set_i), .take_i(take),
    .req_o(req), .pri_o(pri), .gen_o(gen)
  );

  vic_arb u_arb (
    .req_i(req), .pri_i(pri),
    .win_valid_o(win_valid), .win_hi_o(win_hi), .win_idx_o(win_idx)
  );

  vic_svc #(.VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)) u_svc (
    .clk_i, .rst_ni,
    .win_valid_i(win_valid), .win_hi_i(win_hi), .win_idx_i(win_idx),
    .reti_i, .take_o(take), .ack_o, .vector_o
  );

  AST_GLOBAL_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen |=> !ack_o); // R3
  AST_TAKE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take)); // R7
endmodule

// File: tb/vic_top_test.sv
module vic_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [5:0] evt = '0;
  logic       reti = 1'b0;
  logic       ack;
  logic [15:0] vec;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  vic_top uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .evt_set_i(evt), .reti_i(reti), .ack_o(ack), .vector_o(vec)
  );

  function automatic logic [15:0] vaddr(int i);
    return 16'(3 + 8 * i);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic pulse_evt(logic [5:0] s);
    @(negedge clk); evt = s;
    @(negedge clk); evt = '0;
  endtask

  task automatic do_reti();
    @(negedge clk); reti = 1'b1;
    @(negedge clk); reti = 1'b0;
  endtask

  task automatic expect_ack(logic [15:0] exp, string tag);
    logic got = 1'b0;
    logic [15:0] v = '0;
    for (int i = 0; i < 4 && !got; i++) begin
      @(negedge clk);
      if (ack) begin got = 1'b1; v = vec; end
    end
    check({tag, " ack seen"}, 32'(got), 32'd1);
    if (got) check({tag, " vector"}, 32'(v), 32'(exp));
  endtask

  task automatic expect_none(int n, string tag);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (ack) seen++;
    end
    check({tag, " no ack"}, 32'(seen), 32'd0);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R4 ack after reset", 32'(ack), 32'd0);
    rd(2'd0, d); check("R4 enable reset", 32'(d), 32'd0);
    rd(2'd1, d); check("R4 priority reset", 32'(d), 32'd0);
    rd(2'd2, d); check("R4 flags reset", 32'(d), 32'd0);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R2 unused enable bits", 32'(d), 32'h9F);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_global();
    logic [7:0] d;
    wr(2'd0, 8'h1F);
    pulse_evt(6'b000010);
    expect_none(5, "R3 global off");
    wr(2'd0, 8'h9F);
    expect_ack(vaddr(1), "R3 R1 R11 timer0 after global on");
    rd(2'd2, d); check("R8 timer0 flag cleared", 32'(d), 32'h00);
    do_reti();
  endtask

  task automatic t_poll();
    logic [7:0] d;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'h1F);
    expect_ack(vaddr(0), "R7 first ext0");
    rd(2'd2, d); check("R9 ext0 kept", 32'(d), 32'h1F);
    wr(2'd2, 8'h1E); do_reti();
    expect_ack(vaddr(1), "R7 second timer0");
    rd(2'd2, d); check("R8 timer0 cleared in poll", 32'(d), 32'h1C);
    do_reti();
    expect_ack(vaddr(2), "R7 third ext1");
    wr(2'd2, 8'h18); do_reti();
    expect_ack(vaddr(3), "R7 fourth timer1");
    rd(2'd2, d); check("R8 timer1 cleared", 32'(d), 32'h10);
    do_reti();
    expect_ack(vaddr(4), "R7 fifth serial");
    rd(2'd2, d); check("R9 rx kept", 32'(d), 32'h10);
    wr(2'd2, 8'h00); do_reti();
    expect_none(4, "R10 all cleared");
  endtask

  task automatic t_prio();
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h09);
    expect_ack(vaddr(3), "R5 high timer1 first");
    expect_none(5, "R6 high blocks low");
    do_reti();
    expect_ack(vaddr(0), "R12 low after return");
    wr(2'd2, 8'h00); do_reti();
    expect_none(3, "R12 idle");
  endtask

  task automatic t_nest();
    wr(2'd1, 8'h04);
    pulse_evt(6'b010000);
    expect_ack(vaddr(4), "R6 low serial");
    wr(2'd2, 8'h11);
    expect_none(5, "R6 low cannot preempt low");
    pulse_evt(6'b000100);
    expect_ack(vaddr(2), "R6 high preempts low");
    wr(2'd2, 8'h11);
    do_reti();
    expect_none(5, "R12 outer low still active");
    wr(2'd2, 8'h00); do_reti();
    expect_none(3, "R12 nest done");
    wr(2'd1, 8'h00);
  endtask

  task automatic t_swclear();
    logic [7:0] d;
    wr(2'd0, 8'h1F);
    pulse_evt(6'b000010);
    wr(2'd2, 8'h00);
    wr(2'd0, 8'h9F);
    expect_none(5, "R10 cancelled");
    wr(2'd2, 8'h04);
    expect_ack(vaddr(2), "R10 software set");
    wr(2'd2, 8'h00); do_reti();
    pulse_evt(6'b100000);
    expect_ack(vaddr(4), "R9 tx alone");
    rd(2'd2, d); check("R9 tx kept", 32'(d), 32'h20);
    wr(2'd2, 8'h00); do_reti();
    expect_none(3, "R10 quiet");
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_global();
    t_poll();
    t_prio();
    t_nest();
    t_swclear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule